// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and decides, per frame, whether the frame is kept or dropped. It looks only at the 48-bit destination address, which arrives as six bytes in wire order. The first byte is flagged with a start strobe. While the bytes stream in, the block keeps a running CRC-32 of the address. It then issues one accept/reject verdict, which stays on its outputs until the next frame starts.

Four controls are written through a small register port: a station address, a 64-entry multicast hash table, a control that turns broadcast reception off, and a promiscuous control. They are checked in a fixed order of precedence. Promiscuous mode overrides everything. The all-ones broadcast address is governed only by the broadcast control. Any other address with the group bit set is looked up in the hash table. A plain unicast address must equal the station address exactly.

Top module: `mac_rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are 0, and every configuration word reads back as 0.
- R2: Register word index 0 is the mode word, of which only bit 3 (broadcast reject) and bit 5 (promiscuous) are stored. Index 1 holds station address bytes 2,3,4,5 in bits 31:24, 23:16, 15:8, 7:0. Index 2 holds bytes 0 and 1 in bits 15:8 and 7:0, and its bits 31:16 read 0. Index 3 is hash word 0 and index 4 is hash word 1. `cfg_rd_data` shows the word selected by `cfg_addr` one clock after that selection. Indices 5 to 7 read 0 and ignore writes.
- R3: `dec_valid` rises in the clock after the sixth address byte is taken. The verdict then holds, unchanged, through any later bytes that lack a start strobe. It drops in the clock after a byte that carries the start strobe.
- R4: When promiscuous mode is off, a unicast address (bit 0 of byte 0 clear) is accepted only if all 48 bits equal the station address.
- R5: Byte 0 is the first byte on the wire, and it is compared against bits 15:8 of word 2. An address whose bytes are in any other order does not match.
- R6: For a multicast address other than broadcast, the CRC-32 is computed bit-serially over the six bytes, least significant bit of each byte first, with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and no final inversion. CRC bits 31:26 form an index. Index bit 5 selects hash word 1 (set) or hash word 0 (clear), and index bits 4:0 select the bit within that word. The frame is accepted exactly when that bit is 1.
- R7: With both hash words all ones, every multicast address is accepted.
- R8: The broadcast address (all ones) is accepted when mode bit 3 is 0 and rejected when it is 1, whatever the hash table holds.
- R9: When mode bit 5 is 1, every address is accepted, including broadcast with mode bit 3 set.
- R10: A start strobe in the middle of an address discards the partial bytes and begins a new address with that byte as byte 0.
- R11: Cycles with `byte_valid` low between address bytes do not disturb the result. Bytes without a start strobe that arrive while no address is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd_data | output | 32 | Registered read data of the selected word |
| byte_valid | input | 1 | An address byte is present |
| byte_start | input | 1 | This byte is byte 0 of a new address |
| byte_data | input | 8 | Address byte |
| dec_valid | output | 1 | Verdict present (held) |
| dec_accept | output | 1 | Verdict: 1 keeps the frame |

## Verification
The checker takes for granted that a start strobe only comes together with `byte_valid`. It also assumes that the mode word does not change between the sixth address byte and the clock that registers the verdict, because the promiscuous property compares against the previous cycle's mode. The bench keeps within both assumptions: it raises `byte_start` only on valid bytes, and it writes configuration only while no address is in flight. Expected verdicts come from an independent bit-serial CRC model and a shadow copy of the words the bench has written.

// File: rtl/afilt_pkg.sv
package afilt_pkg;
  localparam int ADDR_BYTES  = 6;
  localparam int ADDR_W      = 8 * ADDR_BYTES;
  localparam int CRC_W       = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;
  localparam int HASH_W      = 64;
  localparam int HASH_IDX_W  = $clog2(HASH_W);
  localparam int MODE_BREJ_BIT = 3;
  localparam int MODE_PROM_BIT = 5;
  localparam int REG_MODE    = 0;
  localparam int REG_STA_LO  = 1;
  localparam int REG_STA_HI  = 2;
  localparam int REG_HASH0   = 3;

  typedef enum logic [1:0] {DST_UNICAST, DST_MULTICAST, DST_BROADCAST} dst_kind_e;

  // One address byte, least significant bit first.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int b = 0; b < 8; b++) begin
      fb = r[CRC_W-1] ^ d[b];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/afilt_cfg_regs.sv
module afilt_cfg_regs
  import afilt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_AW = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic [DATA_W-1:0]          cfg_rd_data,
  output logic [DATA_W-1:0]          mode_word,
  output logic [ADDR_W-1:0]          station,
  output logic [HASH_W-1:0]          hash_tbl
);
  localparam int STA_HI_W   = ADDR_W - DATA_W;
  localparam int HASH_WORDS = HASH_W / DATA_W;

  logic              prom_q, brej_q;
  logic [DATA_W-1:0] sta_lo_q;
  logic [STA_HI_W-1:0] sta_hi_q;
  logic [HASH_W-1:0] hash_q;
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      prom_q   <= 1'b0;
      brej_q   <= 1'b0;
      sta_lo_q <= '0;
      sta_hi_q <= '0;
      hash_q   <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == CFG_AW'(REG_MODE)) begin
        prom_q <= cfg_wdata[MODE_PROM_BIT];
        brej_q <= cfg_wdata[MODE_BREJ_BIT];
      end
      if (cfg_addr == CFG_AW'(REG_STA_LO)) sta_lo_q <= cfg_wdata;
      if (cfg_addr == CFG_AW'(REG_STA_HI)) sta_hi_q <= cfg_wdata[STA_HI_W-1:0];
      for (int k = 0; k < HASH_WORDS; k++)
        if (cfg_addr == CFG_AW'(REG_HASH0 + k)) hash_q[k*DATA_W +: DATA_W] <= cfg_wdata;
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[MODE_PROM_BIT] = prom_q;
    mode_word[MODE_BREJ_BIT] = brej_q;
    rd_mux = '0;
    if (cfg_addr == CFG_AW'(REG_MODE))   rd_mux = mode_word;
    if (cfg_addr == CFG_AW'(REG_STA_LO)) rd_mux = sta_lo_q;
    if (cfg_addr == CFG_AW'(REG_STA_HI)) rd_mux = DATA_W'(sta_hi_q);
    for (int k = 0; k < HASH_WORDS; k++)
      if (cfg_addr == CFG_AW'(REG_HASH0 + k)) rd_mux = hash_q[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rd_data <= '0;
    else     cfg_rd_data <= rd_mux;
  end

  assign station  = {sta_hi_q, sta_lo_q};
  assign hash_tbl = hash_q;
endmodule

// File: rtl/afilt_capture.sv
module afilt_capture
  import afilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic              byte_start,
  input  logic [7:0]        byte_data,
  output logic              last_byte,
  output logic [ADDR_W-1:0] addr_now,
  output logic [CRC_W-1:0]  crc_now
);
  localparam int CNT_W = $clog2(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [CRC_W-1:0] crc_q;
  logic [7:0]       held_q [ADDR_BYTES-1];
  logic             take;
  logic [CNT_W-1:0] pos;

  always_comb begin
    take      = byte_valid && (byte_start || busy_q);
    pos       = byte_start ? '0 : cnt_q;
    crc_now   = crc_byte(byte_start ? CRC_INIT : crc_q, byte_data);
    last_byte = take && (pos == LAST_POS);
    for (int i = 0; i < ADDR_BYTES - 1; i++)
      addr_now[ADDR_W-1-8*i -: 8] = held_q[i];
    addr_now[7:0] = byte_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      crc_q  <= CRC_INIT;
      for (int i = 0; i < ADDR_BYTES - 1; i++) held_q[i] <= '0;
    end else if (take) begin
      crc_q  <= crc_now;
      cnt_q  <= pos + CNT_W'(1);
      busy_q <= !last_byte;
      if (pos != LAST_POS) held_q[pos] <= byte_data;
    end
  end
endmodule

// File: rtl/afilt_decide.sv
module afilt_decide
  import afilt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_now,
  input  logic [CRC_W-1:0]  crc_now,
  input  logic [ADDR_W-1:0] station,
  input  logic [HASH_W-1:0] hash_tbl,
  input  logic              promisc,
  input  logic              bcast_rej,
  output logic              accept
);
  dst_kind_e              kind;
  logic [HASH_IDX_W-1:0]  hidx;

  always_comb begin
    if (&addr_now)                kind = DST_BROADCAST;
    else if (addr_now[ADDR_W-8])  kind = DST_MULTICAST;
    else                          kind = DST_UNICAST;
    hidx = crc_now[CRC_W-1 -: HASH_IDX_W];
    if (promisc) accept = 1'b1;
    else begin
      unique case (kind)
        DST_BROADCAST: accept = !bcast_rej;
        DST_MULTICAST: accept = hash_tbl[hidx];
        default:       accept = (addr_now == station);
      endcase
    end
  end
endmodule

// File: rtl/mac_rx_addr_filter.sv
module mac_rx_addr_filter
  import afilt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CFG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rd_data,
  input  logic              byte_valid,
  input  logic              byte_start,
  input  logic [7:0]        byte_data,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic [DATA_W-1:0] mode_q;
  logic [ADDR_W-1:0] station, addr_now;
  logic [HASH_W-1:0] hash_tbl;
  logic [CRC_W-1:0]  crc_now;
  logic              last_byte, accept;

  afilt_cfg_regs #(.DATA_W(DATA_W), .CFG_AW(CFG_AW)) i_regs (
    .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rd_data,
    .mode_word(mode_q), .station, .hash_tbl
  );

  afilt_capture i_cap (
    .clk, .rst, .byte_valid, .byte_start, .byte_data,
    .last_byte, .addr_now, .crc_now
  );

  afilt_decide i_dec (
    .addr_now, .crc_now, .station, .hash_tbl,
    .promisc(mode_q[MODE_PROM_BIT]), .bcast_rej(mode_q[MODE_BREJ_BIT]),
    .accept
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else if (byte_valid && byte_start) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else if (last_byte) begin
      dec_valid  <= 1'b1;
      dec_accept <= accept;
    end
  end
endmodule

// File: rtl/mac_rx_addr_filter_chk.sv
module mac_rx_addr_filter_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              byte_valid,
  input logic              byte_start,
  input logic              dec_valid,
  input logic              dec_accept,
  input logic [DATA_W-1:0] mode_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dec_valid && !dec_accept));

  // R3
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_start) |=> !dec_valid);

  // R3
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !(byte_valid && byte_start)) |=> (dec_valid && $stable(dec_accept)));

  // R3
  rise_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_valid) |-> ($past(byte_valid) && !$past(byte_start)));

  // R9
  promisc_accept_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dec_valid) && $past(mode_q[5])) |-> dec_accept);
endmodule

bind mac_rx_addr_filter mac_rx_addr_filter_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_start(byte_start),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .mode_q(mode_q)
);

// File: tb/test_mac_rx_addr_filter.sv
module test_mac_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rd_data;
  logic        byte_valid = 1'b0, byte_start = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        dec_valid, dec_accept;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  logic [31:0] m_mode = '0, m_lo = '0, m_hi = '0, m_h0 = '0, m_h1 = '0;
  localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] BCAST = '1;

  always #2 clk = ~clk;

  mac_rx_addr_filter i_mac_rx_addr_filter (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    case (idx)
      3'd0: m_mode = d & 32'h28;
      3'd1: m_lo = d;
      3'd2: m_hi = {16'h0, d[15:0]};
      3'd3: m_h0 = d;
      3'd4: m_h1 = d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] idx, input logic [31:0] exp, input string req);
    @(negedge clk); cfg_addr = idx;
    @(negedge clk);
    chk(cfg_rd_data == exp, req, $sformatf("read word %0d", idx), cfg_rd_data, exp);
  endtask

  function automatic logic [5:0] m_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ a[47-8*i-7+j];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    return c[31:26];
  endfunction

  function automatic bit m_accept(input logic [47:0] a);
    logic [63:0] h = {m_h1, m_h0};
    if (m_mode[5]) return 1'b1;
    if (a == BCAST) return !m_mode[3];
    if (a[40]) return h[m_index(a)];
    return a == {m_hi[15:0], m_lo};
  endfunction

  // Sends six bytes with optional idle gaps, then checks the verdict.
  task automatic send(input logic [47:0] a, input int gap, input string req);
    bit exp = m_accept(a);
    for (int i = 0; i < 6; i++) begin
      if (i > 0)
        for (int g = 0; g < gap; g++) begin @(negedge clk); byte_valid = 1'b0; end
      @(negedge clk);
      if (i == 5) chk(dec_valid == 1'b0, "R3", "valid before sixth byte", dec_valid, 0);
      byte_valid = 1'b1; byte_start = (i == 0); byte_data = a[47-8*i -: 8];
    end
    @(negedge clk); byte_valid = 1'b0; byte_start = 1'b0;
    chk(dec_valid == 1'b1, req, "valid after sixth byte", dec_valid, 1);
    chk(dec_accept == exp, req, $sformatf("verdict for %012h", a), dec_accept, exp);
  endtask

  task automatic t_reset();
    chk(!dec_valid && !dec_accept, "R1", "outputs at reset", {dec_valid, dec_accept}, 0);
    for (int k = 0; k < 8; k++) rd_chk(3'(k), 32'h0, "R1");
  endtask

  task automatic t_regs();
    wr(3'd0, 32'hFFFF_FFFF); rd_chk(3'd0, 32'h28, "R2");
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hABCD_0211); rd_chk(3'd2, 32'h0000_0211, "R2");
    wr(3'd1, 32'h2233_4455); rd_chk(3'd1, 32'h2233_4455, "R2");
    wr(3'd3, 32'h1234_5678); rd_chk(3'd3, 32'h1234_5678, "R2");
    wr(3'd4, 32'h9ABC_DEF0); rd_chk(3'd4, 32'h9ABC_DEF0, "R2");
    wr(3'd6, 32'hFFFF_FFFF); rd_chk(3'd6, 32'h0, "R2");
    rd_chk(3'd1, 32'h2233_4455, "R2");
    wr(3'd3, 32'h0); wr(3'd4, 32'h0);
  endtask

  task automatic t_unicast();
    send(STA, 0, "R4");
    send(STA ^ 48'h1, 0, "R4");
    send(STA ^ 48'h0000_0100_0000, 0, "R4");
    send(48'h55_44_33_22_11_02, 0, "R5");
    send(48'h22_33_44_55_02_11, 0, "R5");
  endtask

  task automatic t_hash();
    logic [47:0] a = 48'h01_00_5E_00_00_01;
    logic [47:0] b = 48'h01_00_5E_00_00_02;
    logic [5:0] ia = m_index(a);
    for (int k = 2; k < 64 && m_index(b) == ia; k++) b = 48'h01_00_5E_00_00_00 | 48'(k);
    if (ia[5]) wr(3'd4, 32'h1 << ia[4:0]); else wr(3'd3, 32'h1 << ia[4:0]);
    send(a, 0, "R6");
    send(b, 0, "R6");
    wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    send(a, 0, "R6");
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    send(b, 0, "R7");
    send(48'h33_33_00_00_00_FB, 0, "R7");
    wr(3'd3, 32'h0); wr(3'd4, 32'h0);
  endtask

  task automatic t_bcast();
    send(BCAST, 0, "R8");
    wr(3'd0, 32'h8);
    send(BCAST, 0, "R8");
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    send(BCAST, 0, "R8");
    wr(3'd3, 32'h0); wr(3'd4, 32'h0);
  endtask

  task automatic t_promisc();
    wr(3'd0, 32'h28);
    send(BCAST, 0, "R9");
    send(48'h0A_0B_0C_0D_0E_0F, 0, "R9");
    send(48'h01_80_C2_00_00_0E, 0, "R9");
    wr(3'd0, 32'h0);
  endtask

  task automatic t_hold();
    send(STA, 0, "R3");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_start = 1'b0; byte_data = 8'h00;
      @(negedge clk); byte_valid = 1'b0;
      chk(dec_valid && dec_accept, "R3", "held through payload", {dec_valid, dec_accept}, 3);
    end
    @(negedge clk); byte_valid = 1'b1; byte_start = 1'b1; byte_data = 8'h02;
    @(negedge clk); byte_valid = 1'b0; byte_start = 1'b0;
    chk(!dec_valid, "R3", "cleared by start", dec_valid, 0);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_start = (i == 0); byte_data = 8'hEE;
    end
    send(STA, 0, "R10");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_start = (i == 0); byte_data = STA[47-8*i -: 8];
    end
    send(48'h01_00_5E_7F_FF_FA, 0, "R10");
  endtask

  task automatic t_gaps();
    send(STA ^ 48'h2, 0, "R11");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_start = 1'b0; byte_data = STA[47-8*i -: 8];
    end
    @(negedge clk); byte_valid = 1'b0;
    chk(dec_valid && !dec_accept, "R11", "idle bytes ignored", {dec_valid, dec_accept}, 2);
    send(STA, 3, "R11");
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd4, 32'hFFFF_FFFF);
    send(48'h01_00_5E_01_02_03, 2, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    wr(3'd2, 32'h0000_0211); wr(3'd1, 32'h2233_4455);
    t_unicast();
    t_hash();
    t_bcast();
    wr(3'd0, 32'h0);
    t_promisc();
    t_hold();
    t_restart();
    t_gaps();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule